// File: doc/BRIEF.md
# Byte-Oriented Serial Peripheral Slave with Receive Buffer

This block is the receiving end of a four-wire serial peripheral link. While the select input is held low it exchanges whole bytes with the external master, most significant bit first. Each bit is taken in from the data-in pin and a bit of the transmit holding register is driven out. The pin inputs are brought into the system clock domain through synchronizer stages. All edge decisions are made on the synchronized copies, so the serial clock must be several times slower than the system clock.

A host uses a small register port: a control register, a status register and a data location. Reading the data location returns the last complete received byte, which is kept apart from the shifter. Writing the data location loads the next byte to send. A done flag and an optional interrupt line report every finished byte. Raising select at any moment clears the shifter and the bit counter, so a frame cut short never leaves bits behind. The next low period on select starts on a fresh byte boundary.

Top module: `spi_byte_slave`

## Requirements
- R1: While select is high the block is passive. The output enable stays low, serial clock pulses set no done flag, and the receive buffer keeps its value.
- R2: The output enable is high only while select is low and control bit 1 (drive enable) is set.
- R3: After the eighth sampling edge of a byte, status bit 0 (done) reads 1.
- R4: The interrupt output equals done AND control bit 0 (interrupt enable). With the enable clear, a finished byte leaves the interrupt low.
- R5: Reading register address 2 returns the last complete received byte, shifted in MSB first. A byte written to address 2 while select is high is driven out MSB first once select goes low.
- R6: Raising select drops a partial byte. The done flag stays clear, and the next selection receives its first byte without any left-over bits.
- R7: A read of status (address 1) while a flag is set, followed by a read of address 2, clears done and collision. A read of address 2 without the status read first leaves done set.
- R8: Control bit 2 sets the clock idle level and control bit 3 the phase. With phase 0 data is sampled on the leading edge (the edge leaving idle). With phase 1 it is sampled on the trailing edge. All four combinations transfer correctly.
- R9: A write to address 2 while a byte is part-way through (bit count non-zero) sets status bit 1 (collision) and is discarded. The byte in flight and the following byte both carry the older transmit value.
- R10: Several bytes may follow each other within one selection. Each finished byte overwrites the receive buffer. With phase 1, a transmit value written between bytes is sent in the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the serial data pin |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bytes and two synchronizer stages. The serial clock half-period is ten system cycles, so every edge clears the synchronizer and the edge detector well before the bench samples. This makes it practical to sweep all four clock modes against six byte patterns, each in both directions. It also puts the timing corner cases within reach: a frame cut short after five bits, a host write three bits into a byte, and two bytes inside a single selection.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  localparam int CTL_IE   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_CPOL = 2;
  localparam int CTL_CPHA = 3;

  localparam int STAT_DONE = 0;
  localparam int STAT_COLL = 1;

  // An edge is leading when the line leaves its idle level.
  function automatic logic is_leading(input logic prev_lvl, input logic idle_lvl);
    return prev_lvl == idle_lvl;
  endfunction

  // Phase 0 samples on the leading edge, phase 1 on the trailing edge.
  function automatic logic is_sample(input logic leading, input logic phase);
    return phase ? !leading : leading;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= INIT;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_act,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_hold,
  output logic              tx_bit,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_q, ss_q;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic [CNT_W-1:0]  cnt;

  logic edge_seen, lead, samp_ev, shift_ev, start_ev;

  assign edge_seen = ss_act && ss_q && (sclk_s != sclk_q);
  assign lead      = is_leading(sclk_q, cpol);
  assign samp_ev   = edge_seen && is_sample(lead, cpha);
  assign shift_ev  = edge_seen && !is_sample(lead, cpha);
  assign start_ev  = ss_act && !ss_q;

  assign byte_done = samp_ev && (cnt == LAST);
  assign rx_byte   = {rx_sh[DATA_W-2:0], mosi_s};
  assign busy      = ss_act && (cnt != '0);
  assign tx_bit    = tx_sh[DATA_W-1];
  assign bit_cnt   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_act;
      if (!ss_act) begin
        rx_sh <= '0;
        tx_sh <= '0;
        cnt   <= '0;
      end else begin
        if (start_ev && !cpha) tx_sh <= tx_hold;
        else if (shift_ev) tx_sh <= (cnt == '0) ? tx_hold : {tx_sh[DATA_W-2:0], 1'b0};
        if (samp_ev) begin
          rx_sh <= rx_byte;
          cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              busy,
  output logic              ie,
  output logic              dir_en,
  output logic              cpol,
  output logic              cpha,
  output logic [DATA_W-1:0] tx_hold,
  output logic [DATA_W-1:0] rx_buf,
  output logic              done_flag,
  output logic              coll_flag
);
  logic armed;
  logic wr_ctl, wr_dat, rd_sts, rd_dat, clr;

  assign wr_ctl = wr_en && (addr == REG_CTL);
  assign wr_dat = wr_en && (addr == REG_DATA);
  assign rd_sts = rd_en && (addr == REG_STAT);
  assign rd_dat = rd_en && (addr == REG_DATA);
  assign clr    = rd_dat && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; dir_en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0;
      tx_hold <= '0; rx_buf <= '0;
      done_flag <= 1'b0; coll_flag <= 1'b0; armed <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ie     <= wdata[CTL_IE];
        dir_en <= wdata[CTL_DIR];
        cpol   <= wdata[CTL_CPOL];
        cpha   <= wdata[CTL_CPHA];
      end
      if (wr_dat && !busy) tx_hold <= wdata;
      if (wr_dat && busy) coll_flag <= 1'b1;
      else if (clr) coll_flag <= 1'b0;
      if (byte_done) begin
        done_flag <= 1'b1;
        rx_buf    <= rx_byte;
      end else if (clr) done_flag <= 1'b0;
      if (rd_sts && (done_flag || coll_flag)) armed <= 1'b1;
      else if (rd_dat) armed <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_CTL: begin
        rdata[CTL_IE]   = ie;
        rdata[CTL_DIR]  = dir_en;
        rdata[CTL_CPOL] = cpol;
        rdata[CTL_CPHA] = cpha;
      end
      REG_STAT: begin
        rdata[STAT_DONE] = done_flag;
        rdata[STAT_COLL] = coll_flag;
      end
      REG_DATA: rdata = rx_buf;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              sclk_s, ss_n_s, mosi_s, ss_act;
  logic              ie, dir_en, cpol, cpha;
  logic              byte_done, busy, done_flag, coll_flag;
  logic [DATA_W-1:0] rx_byte, rx_buf, tx_hold;
  logic [CNT_W-1:0]  bit_cnt;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_ss_n, spi_mosi}),
    .q({sclk_s, ss_n_s, mosi_s})
  );

  assign ss_act = !ss_n_s;

  spi_bit_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .cpol(cpol), .cpha(cpha), .tx_hold(tx_hold), .tx_bit(spi_miso),
    .byte_done(byte_done), .rx_byte(rx_byte), .busy(busy), .bit_cnt(bit_cnt)
  );

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr), .rd_en(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .byte_done(byte_done), .rx_byte(rx_byte),
    .busy(busy), .ie(ie), .dir_en(dir_en), .cpol(cpol), .cpha(cpha),
    .tx_hold(tx_hold), .rx_buf(rx_buf), .done_flag(done_flag), .coll_flag(coll_flag)
  );

  assign spi_miso_oe = ss_act && dir_en;
  assign irq         = done_flag && ie;
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_act,
  input logic              miso_oe,
  input logic              byte_done,
  input logic              irq,
  input logic              ie,
  input logic              done_flag,
  input logic              coll_flag,
  input logic              busy,
  input logic              host_wr,
  input logic [1:0]        host_addr,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] rx_byte,
  input logic [DATA_W-1:0] rx_buf,
  input logic [DATA_W-1:0] tx_hold
);
  p_passive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |-> (!miso_oe && !byte_done));

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_flag);

  p_irq_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ie) |=> irq);

  p_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (rx_buf == $past(rx_byte)));

  p_drop_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> (bit_cnt == '0));

  p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd2 && busy) |=> (coll_flag && $stable(tx_hold)));
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .miso_oe(spi_miso_oe),
  .byte_done(byte_done), .irq(irq), .ie(ie), .done_flag(done_flag),
  .coll_flag(coll_flag), .busy(busy), .host_wr(reg_wr), .host_addr(reg_addr),
  .bit_cnt(bit_cnt), .rx_byte(rx_byte), .rx_buf(rx_buf), .tx_hold(tx_hold)
);

// File: tb/sim_spi_byte_slave.sv
module sim_spi_byte_slave;
  localparam int H = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk, ss_n, mosi;
  logic       miso, miso_oe, irq;
  logic [1:0] addr;
  logic       wr, rd;
  logic [7:0] wdata, rdata;
  int n_chk = 0, n_bad = 0;
  logic cpol_m = 1'b0, cpha_m = 1'b0;

  always #2 clk = ~clk;

  spi_byte_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_ss_n(ss_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(addr), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic ien, input logic dir);
    cpol_m = pol; cpha_m = pha; sclk = pol;
    hwrite(2'd0, {4'b0, pha, pol, dir, ien});
    idle(H);
  endtask

  task automatic sel();   ss_n = 1'b0; idle(H); endtask
  task automatic desel(); ss_n = 1'b1; idle(H); endtask

  task automatic xbit(input logic b, output logic o);
    if (!cpha_m) begin
      mosi = b; idle(H); o = miso;
      sclk = ~cpol_m; idle(H); sclk = cpol_m;
    end else begin
      sclk = ~cpol_m; mosi = b; idle(H); o = miso;
      sclk = cpol_m; idle(H);
    end
  endtask

  task automatic xbits(input logic [7:0] mo, input int n, output logic [7:0] mi);
    logic b;
    mi = '0;
    for (int i = 0; i < n; i++) begin
      xbit(mo[7-i], b);
      mi = {mi[6:0], b};
    end
    idle(H);
  endtask

  function automatic logic [7:0] pat(input int k);
    case (k % 6)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      3: return 8'h5A;
      4: return 8'h01;
      default: return 8'h80;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, got, tx, rxv;
    rst_n = 1'b0; sclk = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    idle(5); rst_n = 1'b1; idle(5);

    // Reset state
    hread(2'd0, d); check("R8 reset ctl", d, 8'h00);
    hread(2'd1, d); check("R3 reset status", d, 8'h00);
    hread(2'd2, d); check("R5 reset rx buffer", d, 8'h00);
    check("R2 reset oe", miso_oe, 1'b0);
    check("R4 reset irq", irq, 1'b0);

    // R2: drive enable gating
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    sel(); check("R2 oe with drive off", miso_oe, 1'b0);
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 oe with drive on", miso_oe, 1'b1);
    desel(); check("R1 oe while deselected", miso_oe, 1'b0);

    // R1: clocks while deselected are ignored
    for (int i = 0; i < 8; i++) begin
      mosi = 1'b1; sclk = 1'b1; idle(H); sclk = 1'b0; idle(H);
    end
    hread(2'd1, d); check("R1 no done while deselected", d[0], 1'b0);
    hread(2'd2, d); check("R1 rx buffer untouched", d, 8'h00);
    check("R1 irq stays low", irq, 1'b0);

    // R8/R5/R3/R4/R7: sweep all modes and patterns
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 6; k++) begin
        set_mode(m[0], m[1], 1'b1, 1'b1);
        tx = pat(k); rxv = pat(k + 2) ^ 8'(m * 8'h11);
        hwrite(2'd2, tx);
        sel();
        xbits(rxv, 8, got);
        check($sformatf("R5 R8 miso mode%0d", m), got, tx);
        check($sformatf("R4 irq mode%0d", m), irq, 1'b1);
        hread(2'd1, d); check($sformatf("R3 done mode%0d", m), d[0], 1'b1);
        hread(2'd2, d); check($sformatf("R5 R8 rx mode%0d", m), d, rxv);
        hread(2'd1, d); check($sformatf("R7 cleared mode%0d", m), d[0], 1'b0);
        check($sformatf("R7 irq cleared mode%0d", m), irq, 1'b0);
        desel();
      end
    end

    // R4: interrupt enable clear
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    hwrite(2'd2, 8'h3C); sel(); xbits(8'hC3, 8, got); desel();
    check("R4 irq masked", irq, 1'b0);
    // R7: data read alone does not clear
    hread(2'd2, d); check("R5 rx with ie off", d, 8'hC3);
    hread(2'd1, d); check("R7 data read alone keeps done", d[0], 1'b1);
    hread(2'd2, d); hread(2'd1, d); check("R7 sequence clears done", d[0], 1'b0);

    // R6: partial byte dropped
    set_mode(1'b1, 1'b0, 1'b1, 1'b1);
    sel(); xbits(8'hFF, 5, got); desel();
    hread(2'd1, d); check("R6 partial sets no done", d[0], 1'b0);
    hread(2'd2, d); check("R6 partial leaves buffer", d, 8'hC3);
    sel(); xbits(8'h29, 8, got); desel();
    hread(2'd1, d); hread(2'd2, d); check("R6 fresh byte after cut", d, 8'h29);

    // R9: collision mid-byte
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    hwrite(2'd2, 8'hB4);
    sel();
    xbits(8'h96, 3, got);
    hwrite(2'd2, 8'h4B);
    begin
      logic [7:0] rest;
      xbits({8'h96 << 3}, 5, rest);
      got = {got[2:0], rest[4:0]};
    end
    check("R9 byte in flight intact", got, 8'hB4);
    hread(2'd1, d); check("R9 collision flag", d[1], 1'b1);
    hread(2'd2, d); check("R9 rx still correct", d, 8'h96);
    xbits(8'h00, 8, got);
    check("R9 discarded write not sent", got, 8'hB4);
    desel();
    hread(2'd1, d); hread(2'd2, d); hread(2'd1, d);
    check("R7 collision cleared", d, 8'h00);

    // R10: two bytes in one selection, phase 1
    set_mode(1'b0, 1'b1, 1'b1, 1'b1);
    hwrite(2'd2, 8'h71);
    sel();
    xbits(8'h1E, 8, got); check("R10 first tx", got, 8'h71);
    hwrite(2'd2, 8'hE2);
    hread(2'd1, d); check("R10 no collision between bytes", d[1], 1'b0);
    xbits(8'hD8, 8, got); check("R10 second tx", got, 8'hE2);
    hread(2'd2, d); check("R10 buffer holds second byte", d, 8'hD8);
    desel();

    summary();
    $finish;
  end
endmodule